// File: doc/BRIEF.md
# Crypto Data Length Tracker

This block holds the number of payload bytes that a block-cipher engine still has to process, and follows that number as the engine consumes data. Software writes the 61-bit byte count as two 32-bit words. A mode input chooses between the plain cipher modes and the two authenticated modes (GCM and CCM). The choice controls how the engine is started and which lengths are legal.

In the plain modes, writing the upper word launches the engine. A count of zero in a plain mode means the stream has no end. In the authenticated modes, a separate go input launches the engine. That go is only honoured when the programmed lengths are legal. Every consume handshake from the engine removes one 16-byte block, or the remaining bytes of a short last block. The block raises a one-cycle done pulse when a finite count reaches zero. Bus reads of the length words always return zero.

Top module: `crypto_len_tracker`

## Requirements
- R1: After reset the stored count is zero, and start, done, busy and the error flag are low.
- R2: A write with `bus_sel_hi`=0 loads count bits 31:0 from `bus_wdata`. A write with `bus_sel_hi`=1 loads count bits 60:32 from `bus_wdata[28:0]`. Bits 31:29 of the upper word are ignored.
- R3: `bus_rdata` is always zero, whatever count is stored.
- R4: Mode encoding is 0 or 3 = plain, 1 = GCM, 2 = CCM. In a plain mode, a write to the upper word gives a `start` pulse of exactly one cycle, in the cycle after the write. In GCM or CCM the same write gives no start.
- R5: While busy, each `consume` cycle subtracts 16 from the count, or the whole count when fewer than 16 bytes remain. `last_bytes` shows min(16, count).
- R6: When a finite count reaches zero, `done` pulses for one cycle and busy drops. The count then stays at zero under further consume cycles.
- R7: A plain-mode start with a count of zero sets `infinite`. While `infinite` is set, consume cycles leave the count at zero and done never pulses.
- R8: In GCM or CCM, a zero count together with `auth_len_nz`=0 raises `len_err`.
- R9: In GCM, a count above 2^36-32 (0xF_FFFF_FFE0) raises `len_err`, and exactly 2^36-32 does not. CCM has no such limit.
- R10: In GCM or CCM, `aead_go` gives a one-cycle start in the next cycle only when `len_err` is low. With a legal zero count (authentication data only), start and done pulse in the same cycle and busy stays low.
- R11: While not busy, `consume` leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Length word write strobe |
| bus_sel_hi | input | 1 | 0 selects lower word, 1 selects upper word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| mode | input | 2 | Cipher mode: 0/3 plain, 1 GCM, 2 CCM |
| auth_len_nz | input | 1 | Authentication length is nonzero |
| aead_go | input | 1 | Start request for GCM and CCM |
| consume | input | 1 | Engine has taken one block |
| start | output | 1 | One-cycle engine start |
| done | output | 1 | One-cycle end-of-data pulse |
| busy | output | 1 | Processing in progress |
| infinite | output | 1 | Running with unbounded length |
| len_err | output | 1 | Programmed length is illegal for the mode |
| remaining | output | 61 | Bytes still to be processed |
| last_bytes | output | 5 | Valid bytes in the current block |

## Verification
A corrupted count shows at `remaining` and `last_bytes` in the cycle after the faulty update. It also moves the done pulse to the wrong consume cycle, so a miscount of even one block shows up within that block. A wrong busy or infinite state shows up as a missing or stray `start`, as a count that moves while idle, or as a done that never comes. Each of these is visible within one cycle of the next write, go or consume.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    CM_PLAIN     = 2'd0,
    CM_GCM       = 2'd1,
    CM_CCM       = 2'd2,
    CM_PLAIN_ALT = 2'd3
  } cmode_e;

  function automatic logic is_aead(input logic [1:0] m);
    return (m == CM_GCM) || (m == CM_CCM);
  endfunction

  // bytes removed by one consume step
  function automatic logic [63:0] take_bytes(input logic [63:0] rem, input logic [63:0] blk);
    return (rem < blk) ? rem : blk;
  endfunction

  // largest byte count a counter of ctr_w bits can cover
  function automatic logic [63:0] gcm_max(input int ctr_w, input int blk);
    return ((64'd1 << ctr_w) - 64'd2) * 64'(blk);
  endfunction
endpackage

// File: rtl/cl_len_store.sv
module cl_len_store #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 61,
  parameter int BLK    = 16,
  localparam int HI_W  = LEN_W - WORD_W,
  localparam int CNT_W = $clog2(BLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              dec_en,
  output logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  last_bytes
);
  logic [63:0] step_w;
  logic        unused_bits;

  assign step_w      = cl_pkg::take_bytes(64'(len), 64'(BLK));
  assign last_bytes  = step_w[CNT_W-1:0];
  assign unused_bits = ^{step_w[63:CNT_W], wdata[WORD_W-1:HI_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0;
    end else if (wr_lo) begin
      len[WORD_W-1:0] <= wdata;
    end else if (wr_hi) begin
      len[LEN_W-1:WORD_W] <= wdata[HI_W-1:0];
    end else if (dec_en) begin
      len <= len - step_w[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/cl_len_check.sv
module cl_len_check #(
  parameter int LEN_W = 61,
  parameter int BLK   = 16,
  parameter int CTR_W = 32
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       mode,
  input  logic             auth_nz,
  output logic             err
);
  localparam logic [63:0] GCM_LIMIT = cl_pkg::gcm_max(CTR_W, BLK);

  logic both_zero;
  logic too_long;

  assign both_zero = (len == '0) && !auth_nz;
  assign too_long  = (mode == cl_pkg::CM_GCM) && (64'(len) > GCM_LIMIT);
  assign err       = cl_pkg::is_aead(mode) && (both_zero || too_long);
endmodule

// File: rtl/cl_run_ctrl.sv
module cl_run_ctrl #(
  parameter int LEN_W = 61,
  parameter int BLK   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_any,
  input  logic             wr_hi,
  input  logic [1:0]       mode,
  input  logic             aead_go,
  input  logic             err,
  input  logic             consume,
  input  logic [LEN_W-1:0] len,
  output logic             start,
  output logic             done,
  output logic             busy,
  output logic             infinite,
  output logic             dec_en
);
  logic aead;
  logic go_plain;
  logic go_aead;
  logic go_evt;
  logic zero_aead;
  logic finish;

  assign aead      = cl_pkg::is_aead(mode);
  assign go_plain  = wr_hi && !aead;
  assign go_aead   = aead_go && aead && !err;
  assign go_evt    = go_plain || go_aead;
  assign zero_aead = go_aead && (len == '0);
  assign infinite  = busy && (len == '0);
  assign dec_en    = busy && consume && !infinite && !wr_any;
  assign finish    = dec_en && (64'(len) <= 64'(BLK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start <= 1'b0;
      done  <= 1'b0;
      busy  <= 1'b0;
    end else begin
      start <= go_evt;
      done  <= finish || zero_aead;
      if (go_evt && !zero_aead) busy <= 1'b1;
      else if (finish)          busy <= 1'b0;
    end
  end
endmodule

// File: rtl/crypto_len_tracker.sv
module crypto_len_tracker #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 61,
  parameter int BLK    = 16,
  parameter int CTR_W  = 32,
  localparam int CNT_W = $clog2(BLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel_hi,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [1:0]        mode,
  input  logic              auth_len_nz,
  input  logic              aead_go,
  input  logic              consume,
  output logic              start,
  output logic              done,
  output logic              busy,
  output logic              infinite,
  output logic              len_err,
  output logic [LEN_W-1:0]  remaining,
  output logic [CNT_W-1:0]  last_bytes
);
  logic wr_lo;
  logic wr_hi;
  logic dec_en;

  assign wr_lo     = bus_wr && !bus_sel_hi;
  assign wr_hi     = bus_wr && bus_sel_hi;
  assign bus_rdata = '0;

  cl_len_store #(.WORD_W(WORD_W), .LEN_W(LEN_W), .BLK(BLK)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .dec_en(dec_en), .len(remaining), .last_bytes(last_bytes)
  );

  cl_len_check #(.LEN_W(LEN_W), .BLK(BLK), .CTR_W(CTR_W)) u_check (
    .len(remaining), .mode(mode), .auth_nz(auth_len_nz), .err(len_err)
  );

  cl_run_ctrl #(.LEN_W(LEN_W), .BLK(BLK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_any(bus_wr), .wr_hi(wr_hi), .mode(mode),
    .aead_go(aead_go), .err(len_err), .consume(consume), .len(remaining),
    .start(start), .done(done), .busy(busy), .infinite(infinite), .dec_en(dec_en)
  );
endmodule

// File: rtl/crypto_len_tracker_chk.sv
module crypto_len_tracker_chk #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 61,
  parameter int BLK    = 16,
  parameter int CTR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [1:0]        mode,
  input logic              auth_len_nz,
  input logic              aead_go,
  input logic              start,
  input logic              done,
  input logic              busy,
  input logic              infinite,
  input logic              len_err,
  input logic [LEN_W-1:0]  remaining,
  input logic              wr_hi,
  input logic              dec_en
);
  localparam int HI_W = LEN_W - WORD_W;
  localparam logic [63:0] LIMIT = cl_pkg::gcm_max(CTR_W, BLK);

  logic aead;
  assign aead = (mode == 2'd1) || (mode == 2'd2);

  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == '0); // R3
  AST_HI_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> remaining[LEN_W-1:WORD_W] == $past(bus_wdata[HI_W-1:0])); // R2
  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($past(wr_hi && !aead) || $past(aead_go && aead && !len_err))); // R4 R10
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> remaining == $past(remaining) -
      (($past(remaining) < LEN_W'(BLK)) ? $past(remaining) : LEN_W'(BLK))); // R5
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remaining == '0) && !busy); // R6
  AST_INF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (infinite && !bus_wr) |=> (remaining == '0) && !done); // R7
  AST_AEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (aead && remaining == '0 && !auth_len_nz) |-> len_err); // R8
  AST_GCM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && 64'(remaining) > LIMIT) |-> len_err); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_wr) |=> $stable(remaining)); // R11
endmodule

bind crypto_len_tracker crypto_len_tracker_chk #(
  .WORD_W(WORD_W), .LEN_W(LEN_W), .BLK(BLK), .CTR_W(CTR_W)
) u_chk (.*);

// File: tb/crypto_len_tracker_test.sv
module crypto_len_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel_hi = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  mode = 2'd0;
  logic        auth_len_nz = 1'b0;
  logic        aead_go = 1'b0;
  logic        consume = 1'b0;
  logic        start, done, busy, infinite, len_err;
  logic [60:0] remaining;
  logic [4:0]  last_bytes;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  crypto_len_tracker uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_hi(bus_sel_hi),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode(mode),
    .auth_len_nz(auth_len_nz), .aead_go(aead_go), .consume(consume),
    .start(start), .done(done), .busy(busy), .infinite(infinite),
    .len_err(len_err), .remaining(remaining), .last_bytes(last_bytes)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_hi = hi; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic eat();
    @(negedge clk);
    consume = 1'b1;
    @(negedge clk);
    consume = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    aead_go = 1'b1;
    @(negedge clk);
    aead_go = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", 64'(remaining), 0);
    chk("R1 start", 64'(start), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 err", 64'(len_err), 0);
  endtask

  task automatic t_plain_run();
    mode = 2'd0;
    wr(1'b0, 32'h1234_5678);
    chk("R4 no start on low write", 64'(start), 0);
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R4 start after high write", 64'(start), 1);
    chk("R2 mapping", 64'(remaining), {3'b0, 29'h1FFF_FFFF, 32'h1234_5678});
    chk("R3 rdata", 64'(bus_rdata), 0);
    @(negedge clk);
    chk("R4 start one cycle", 64'(start), 0);
    eat();
    chk("R5 minus 16", 64'(remaining), {3'b0, 29'h1FFF_FFFF, 32'h1234_5668});
    chk("R5 full block", 64'(last_bytes), 16);
    wr(1'b0, 32'd20);
    wr(1'b1, 32'hE000_0000);
    chk("R2 high bits ignored", 64'(remaining), 20);
    eat();
    chk("R5 20-16", 64'(remaining), 4);
    chk("R5 partial", 64'(last_bytes), 4);
    chk("R6 no early done", 64'(done), 0);
    eat();
    chk("R6 zero", 64'(remaining), 0);
    chk("R6 done", 64'(done), 1);
    chk("R6 busy drop", 64'(busy), 0);
    eat();
    chk("R6 done one cycle", 64'(done), 0);
    chk("R6 stays zero", 64'(remaining), 0);
  endtask

  task automatic t_aead_run();
    mode = 2'd1; auth_len_nz = 1'b0;
    wr(1'b0, 32'd100);
    wr(1'b1, 32'd0);
    chk("R4 no start in GCM", 64'(start), 0);
    eat();
    chk("R11 idle consume", 64'(remaining), 100);
    go();
    chk("R10 start", 64'(start), 1);
    for (int i = 0; i < 6; i++) eat();
    chk("R5 after six", 64'(remaining), 4);
    eat();
    chk("R10 finish", 64'(done), 1);
  endtask

  task automatic t_infinite();
    mode = 2'd3;
    wr(1'b0, 32'd0);
    wr(1'b1, 32'd0);
    chk("R7 start", 64'(start), 1);
    chk("R7 infinite", 64'(infinite), 1);
    for (int i = 0; i < 3; i++) begin
      eat();
      chk("R7 no done", 64'(done), 0);
    end
    chk("R7 count", 64'(remaining), 0);
    wr(1'b0, 32'd5);
    eat();
    chk("R6 done after reload", 64'(done), 1);
  endtask

  task automatic t_legal();
    mode = 2'd2; auth_len_nz = 1'b0;
    @(negedge clk);
    chk("R8 both zero", 64'(len_err), 1);
    go();
    chk("R10 suppressed", 64'(start), 0);
    auth_len_nz = 1'b1;
    @(negedge clk);
    chk("R8 auth only legal", 64'(len_err), 0);
    go();
    chk("R10 zero start", 64'(start), 1);
    chk("R10 zero done", 64'(done), 1);
    chk("R10 zero busy", 64'(busy), 0);
  endtask

  task automatic t_gcm_limit();
    mode = 2'd1;
    wr(1'b0, 32'hFFFF_FFE0);
    wr(1'b1, 32'h0000_000F);
    chk("R9 at limit", 64'(len_err), 0);
    wr(1'b0, 32'hFFFF_FFE1);
    chk("R9 over limit", 64'(len_err), 1);
    go();
    chk("R9 no start", 64'(start), 0);
    mode = 2'd2;
    @(negedge clk);
    chk("R9 CCM no limit", 64'(len_err), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_run();
        t_aead_run();
        t_infinite();
        t_legal();
        t_gcm_limit();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule